// File: doc/BRIEF.md
# Four-Channel Noise-Shaping Requantizer with Segmented DAC Word Output

This block sits between a four-channel up-sampling filter and a segmented current-steering DAC. At every strobe of the four-times-audio-rate clock enable it takes one 22-bit two's-complement sample for each of four channels: front-left, front-right, rear-left and rear-right. It shortens each sample to 15 bits with a first-order error-feedback shaper. Each channel carries its own error state from one strobe to the next, so the requantization noise is pushed out of the audio band.

One requantizer and one field splitter are shared by all four channels, which pass through them one per clock after the strobe. Each 15-bit result is turned into sign-magnitude form. It is then split into three fields: a current-direction bit, a 5-bit coarse value and a 9-bit fine value. The coarse value also drives a 32-line thermometer code that enables the coarse current sources. The four formatted results go into the output latches together on the following strobe, so the analog side always sees one coherent set of four words.

Top module: `ns_dac_formatter`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output field and thermometer line is zero after that edge, and every channel's error state is cleared.
- R2: The outputs change only at a strobe edge, and all four channels update at the same edge. The values shown after strobe k are the results for the samples captured at strobe k-1. The first strobe after reset leaves the outputs at zero.
- R3: For each channel, sum = sample + e, where e is the channel's 7-bit unsigned error. The 15-bit result is floor(sum / 128), and the new error is sum - 128 * result.
- R4: If the sum exceeds 2^21 - 1 the result saturates to +16383. If it falls below -2^21 the result saturates to -16384. In both cases the channel's new error is zero.
- R5: Each channel's error state depends only on that channel's own samples.
- R6: The direction bit is 1 when the 15-bit result is negative. The magnitude is the absolute value of the result, clamped to 16383.
- R7: Coarse is magnitude bits 13..9 and fine is magnitude bits 8..0. Channel c (0 = front-left, 1 = front-right, 2 = rear-left, 3 = rear-right) occupies `dac_sign[c]`, `dac_coarse[5c+4:5c]` and `dac_fine[9c+8:9c]`.
- R8: Thermometer line i of channel c, `dac_therm[32c+i]`, is 1 exactly when i < coarse of that channel.
- R9: Strobes spaced five clocks apart are fully supported. The four channels finish in the four clocks after a strobe, and the shared datapath is idle at every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe | input | 1 | Four-times-rate enable: capture samples and latch results |
| smp_in | input | 88 | Four 22-bit samples, channel c at bits 22c+21..22c |
| dac_sign | output | 4 | Current-direction bit per channel |
| dac_coarse | output | 20 | 5-bit coarse value per channel |
| dac_fine | output | 36 | 9-bit fine value per channel |
| dac_therm | output | 128 | 32-line thermometer code per channel |

## Verification
The assertions rely on two conditions. A new strobe never arrives while the shared datapath is still working through the channels of the previous one, and reset is held for at least one clock edge. The stimulus meets both: it always waits at least four clocks after each strobe, and it uses exactly that minimum spacing in some frames. Inputs are driven on falling edges. The samples mix uniformly random words with the full-scale positive and negative codes, minus one and small values near zero, so the error feedback overflows, saturates and carries into the kept bits.

// File: rtl/nsdf_pkg.sv
// Shared defaults and types for the noise-shaping DAC formatter.
// Assumes: the channel count is a power of two, which lets the sequencer index wrap on its own.
package nsdf_pkg;
    parameter int CHANNELS  = 4;
    parameter int SAMPLE_W  = 22;
    parameter int DAC_W     = 15;
    parameter int FINE_BITS = 9;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/nsdf_shaper.sv
// First-order error-feedback requantizer (combinational).
// Adds the stored low-order error to the sample, keeps the top OUT_W bits
// (floor), returns the dropped bits as the next error, and saturates on overflow.
// Assumes: err_in is unsigned, a value from 0 to 2**(IN_W-OUT_W)-1.
module nsdf_shaper #(
    parameter int IN_W  = 22,
    parameter int OUT_W = 15,
    localparam int ERR_W = IN_W - OUT_W
)(
    input  logic [IN_W-1:0]  smp,
    input  logic [ERR_W-1:0] err_in,
    output logic [OUT_W-1:0] q,
    output logic [ERR_W-1:0] err_out,
    output logic             sat
);
    logic [IN_W:0] sum;
    logic          pos_ovf;
    logic          neg_ovf;

    // Extended-precision sum of sample and carried error.
    assign sum     = {smp[IN_W-1], smp} + {{(OUT_W + 1){1'b0}}, err_in};
    assign pos_ovf = ~sum[IN_W] &  sum[IN_W-1];
    assign neg_ovf =  sum[IN_W] & ~sum[IN_W-1];
    assign sat     = pos_ovf | neg_ovf;

    // Select the kept bits or the saturated extreme, and the next error.
    always_comb begin
        if (pos_ovf) begin
            q = {1'b0, {(OUT_W-1){1'b1}}};
        end else if (neg_ovf) begin
            q = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            q = sum[IN_W-1:ERR_W];
        end
        err_out = sat ? '0 : sum[ERR_W-1:0];
    end
endmodule

// File: rtl/nsdf_split.sv
// Converts a two's-complement word to sign-magnitude form and splits the
// magnitude into coarse (upper) and fine (lower) DAC fields.
// Assumes: the most negative input is clamped to the largest magnitude.
module nsdf_split #(
    parameter int OUT_W  = 15,
    parameter int FINE_W = 9,
    localparam int MAG_W    = OUT_W - 1,
    localparam int COARSE_W = MAG_W - FINE_W
)(
    input  logic [OUT_W-1:0]    q,
    output logic                sign,
    output logic [COARSE_W-1:0] coarse,
    output logic [FINE_W-1:0]   fine
);
    logic [OUT_W-1:0] mag_full;
    logic [MAG_W-1:0] mag;

    // Absolute value, clamped to MAG_W bits.
    assign sign     = q[OUT_W-1];
    assign mag_full = sign ? (~q + OUT_W'(1)) : q;
    assign mag      = mag_full[OUT_W-1] ? '1 : mag_full[MAG_W-1:0];
    assign coarse   = mag[MAG_W-1:FINE_W];
    assign fine     = mag[FINE_W-1:0];
endmodule

// File: rtl/nsdf_therm.sv
// Binary-to-thermometer decoder: line i is set when i is below the code.
// Assumes: the line count is 2**COARSE_W, so the top line is never set.
module nsdf_therm #(
    parameter int COARSE_W = 5,
    localparam int LINES = 1 << COARSE_W
)(
    input  logic [COARSE_W-1:0] coarse,
    output logic [LINES-1:0]    therm
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        // One comparator per line.
        assign therm[i] = (coarse > COARSE_W'(i));
    end
endmodule

// File: rtl/ns_dac_formatter.sv
// Four-channel noise-shaping requantizer and segmented DAC word formatter.
// A strobe captures all samples and launches a one-channel-per-clock pass
// through a shared shaper and splitter. The next strobe moves all finished
// results to the output latches at once.
// Assumes: strobes are at least CH_N+1 clocks apart.
module ns_dac_formatter #(
    parameter int CH_N   = nsdf_pkg::CHANNELS,
    parameter int IN_W   = nsdf_pkg::SAMPLE_W,
    parameter int OUT_W  = nsdf_pkg::DAC_W,
    parameter int FINE_W = nsdf_pkg::FINE_BITS,
    localparam int ERR_W    = IN_W - OUT_W,
    localparam int COARSE_W = OUT_W - 1 - FINE_W,
    localparam int THERM_W  = 1 << COARSE_W,
    localparam int CH_W     = (CH_N > 1) ? $clog2(CH_N) : 1
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strobe,
    input  logic [CH_N*IN_W-1:0]       smp_in,
    output logic [CH_N-1:0]            dac_sign,
    output logic [CH_N*COARSE_W-1:0]   dac_coarse,
    output logic [CH_N*FINE_W-1:0]     dac_fine,
    output logic [CH_N*THERM_W-1:0]    dac_therm
);
    nsdf_pkg::seq_state_e seq_q;
    logic [CH_W-1:0]      ch_idx;
    logic [CH_N-1:0]      done_q;
    logic                 busy;

    logic [IN_W-1:0]      hold_q     [CH_N];
    logic [ERR_W-1:0]     err_q      [CH_N];
    logic                 res_sign   [CH_N];
    logic [COARSE_W-1:0]  res_coarse [CH_N];
    logic [FINE_W-1:0]    res_fine   [CH_N];
    logic                 out_sign   [CH_N];
    logic [COARSE_W-1:0]  out_coarse [CH_N];
    logic [FINE_W-1:0]    out_fine   [CH_N];
    logic [CH_N*ERR_W-1:0] err_flat;

    logic [IN_W-1:0]      cur_smp;
    logic [ERR_W-1:0]     cur_err;
    logic [OUT_W-1:0]     sh_q;
    logic [ERR_W-1:0]     sh_err;
    logic                 sh_sat;
    logic                 sp_sign;
    logic [COARSE_W-1:0]  sp_coarse;
    logic [FINE_W-1:0]    sp_fine;

    assign busy    = (seq_q == nsdf_pkg::SEQ_RUN);
    assign cur_smp = hold_q[ch_idx];
    assign cur_err = err_q[ch_idx];

    // Sequencer: a strobe starts a pass; each busy clock finishes one channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= nsdf_pkg::SEQ_IDLE;
            ch_idx <= '0;
            done_q <= '0;
        end else if (strobe) begin
            seq_q  <= nsdf_pkg::SEQ_RUN;
            ch_idx <= '0;
            done_q <= '0;
        end else if (busy) begin
            done_q[ch_idx] <= 1'b1;
            ch_idx         <= ch_idx + CH_W'(1);
            if (ch_idx == CH_W'(CH_N - 1)) begin
                seq_q <= nsdf_pkg::SEQ_IDLE;
            end
        end
    end

    // Sample capture on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < CH_N; c++) hold_q[c] <= '0;
        end else if (strobe) begin
            for (int c = 0; c < CH_N; c++) hold_q[c] <= smp_in[c*IN_W +: IN_W];
        end
    end

    nsdf_shaper #(.IN_W(IN_W), .OUT_W(OUT_W)) u_shaper (
        .smp     (cur_smp),
        .err_in  (cur_err),
        .q       (sh_q),
        .err_out (sh_err),
        .sat     (sh_sat)
    );

    nsdf_split #(.OUT_W(OUT_W), .FINE_W(FINE_W)) u_split (
        .q      (sh_q),
        .sign   (sp_sign),
        .coarse (sp_coarse),
        .fine   (sp_fine)
    );

    // Per-channel error state and staged results, written by the shared datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < CH_N; c++) begin
                err_q[c]      <= '0;
                res_sign[c]   <= 1'b0;
                res_coarse[c] <= '0;
                res_fine[c]   <= '0;
            end
        end else if (busy && !strobe) begin
            err_q[ch_idx]      <= sh_err;
            res_sign[ch_idx]   <= sp_sign;
            res_coarse[ch_idx] <= sp_coarse;
            res_fine[ch_idx]   <= sp_fine;
        end
    end

    // Output latches: all channels move together on a strobe after a full pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < CH_N; c++) begin
                out_sign[c]   <= 1'b0;
                out_coarse[c] <= '0;
                out_fine[c]   <= '0;
            end
        end else if (strobe && (&done_q)) begin
            for (int c = 0; c < CH_N; c++) begin
                out_sign[c]   <= res_sign[c];
                out_coarse[c] <= res_coarse[c];
                out_fine[c]   <= res_fine[c];
            end
        end
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        assign dac_sign[c]                        = out_sign[c];
        assign dac_coarse[c*COARSE_W +: COARSE_W] = out_coarse[c];
        assign dac_fine[c*FINE_W +: FINE_W]       = out_fine[c];
        assign err_flat[c*ERR_W +: ERR_W]         = err_q[c];

        nsdf_therm #(.COARSE_W(COARSE_W)) u_therm (
            .coarse (out_coarse[c]),
            .therm  (dac_therm[c*THERM_W +: THERM_W])
        );
    end
endmodule

// File: rtl/nsdf_checker.sv
// Property checker for ns_dac_formatter, attached with bind below.
// Assumes: the strobe never arrives while a channel pass is in progress.
module nsdf_checker #(
    parameter int CH_N     = 4,
    parameter int ERR_W    = 7,
    parameter int COARSE_W = 5,
    parameter int FINE_W   = 9,
    parameter int CH_W     = 2,
    localparam int THERM_W = 1 << COARSE_W
)(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      strobe,
    input logic                      busy,
    input logic                      sat,
    input logic [CH_W-1:0]           ch_idx,
    input logic [CH_N*ERR_W-1:0]     err_flat,
    input logic [CH_N-1:0]           dac_sign,
    input logic [CH_N*COARSE_W-1:0]  dac_coarse,
    input logic [CH_N*FINE_W-1:0]    dac_fine,
    input logic [CH_N*THERM_W-1:0]   dac_therm
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (dac_sign == '0 && dac_coarse == '0 && dac_fine == '0 && dac_therm == '0));

    assert_hold_between_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(dac_sign) && $stable(dac_coarse) && $stable(dac_fine)));

    assert_idle_at_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !busy);

    for (genvar c = 0; c < CH_N; c++) begin : g_chk
        logic [THERM_W-1:0] th;
        assign th = dac_therm[c*THERM_W +: THERM_W];

        assert_therm_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(th) == int'(dac_coarse[c*COARSE_W +: COARSE_W]));

        assert_therm_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((th + THERM_W'(1)) & th) == '0);

        assert_sat_clears_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && !strobe && sat && ch_idx == CH_W'(c)) |=> (err_flat[c*ERR_W +: ERR_W] == '0));
    end
endmodule

bind ns_dac_formatter nsdf_checker #(
    .CH_N(CH_N), .ERR_W(ERR_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W), .CH_W(CH_W)
) u_nsdf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .busy       (busy),
    .sat        (sh_sat),
    .ch_idx     (ch_idx),
    .err_flat   (err_flat),
    .dac_sign   (dac_sign),
    .dac_coarse (dac_coarse),
    .dac_fine   (dac_fine),
    .dac_therm  (dac_therm)
);

// File: tb/ns_dac_formatter_test.sv
// Self-checking bench: directed corners plus seeded random frames,
// compared against a behavioural model of the requirements.
module ns_dac_formatter_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strobe = 1'b0;
    logic [87:0]  smp_in = '0;
    logic [3:0]   dac_sign;
    logic [19:0]  dac_coarse;
    logic [35:0]  dac_fine;
    logic [127:0] dac_therm;

    int checks = 0;
    int failures = 0;

    int err_m [4];
    int pend_s [4], pend_c [4], pend_f [4];
    int exp_s [4], exp_c [4], exp_f [4];
    bit pend_valid = 1'b0;

    ns_dac_formatter uut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .smp_in(smp_in),
        .dac_sign(dac_sign), .dac_coarse(dac_coarse), .dac_fine(dac_fine),
        .dac_therm(dac_therm)
    );

    always #5 clk = ~clk;

    // Requantization model (R3, R4).
    function automatic void requant(input int x, input int e, output int q, output int en);
        int s;
        s = x + e;
        if (s > 2097151) begin
            q = 16383; en = 0;
        end else if (s < -2097152) begin
            q = -16384; en = 0;
        end else begin
            q = s >>> 7;
            en = s - q * 128;
        end
    endfunction

    // Sign-magnitude and field split model (R6, R7).
    function automatic void fields(input int q, output int s, output int co, output int fi);
        int m;
        s = (q < 0) ? 1 : 0;
        m = (q < 0) ? -q : q;
        if (m > 16383) m = 16383;
        co = m / 512;
        fi = m % 512;
    endfunction

    task automatic model_reset();
        pend_valid = 1'b0;
        for (int c = 0; c < 4; c++) begin
            err_m[c] = 0; exp_s[c] = 0; exp_c[c] = 0; exp_f[c] = 0;
        end
    endtask

    task automatic check_out(input string tag);
        for (int c = 0; c < 4; c++) begin
            int a_word, e_word;
            logic [31:0] a_th, e_th;
            a_word = {dac_sign[c], dac_coarse[c*5 +: 5], dac_fine[c*9 +: 9]};
            e_word = exp_s[c] * 16384 + exp_c[c] * 512 + exp_f[c];
            checks++;
            if (a_word != e_word) begin
                failures++;
                $display("FAIL %s ch%0d word actual=%h expected=%h", tag, c, a_word, e_word);
            end
            a_th = dac_therm[c*32 +: 32];
            for (int i = 0; i < 32; i++) e_th[i] = (i < exp_c[c]);
            checks++;
            if (a_th != e_th) begin
                failures++;
                $display("FAIL R8 ch%0d therm actual=%h expected=%h", c, a_th, e_th);
            end
        end
    endtask

    // One strobe; gap extra falling edges before the next frame may start.
    task automatic frame(input logic [87:0] xs, input int gap, input string tag);
        @(negedge clk);
        smp_in = xs;
        strobe = 1'b1;
        if (pend_valid) begin
            for (int c = 0; c < 4; c++) begin
                exp_s[c] = pend_s[c]; exp_c[c] = pend_c[c]; exp_f[c] = pend_f[c];
            end
        end
        for (int c = 0; c < 4; c++) begin
            int q, en;
            requant(int'($signed(xs[c*22 +: 22])), err_m[c], q, en);
            err_m[c] = en;
            fields(q, pend_s[c], pend_c[c], pend_f[c]);
        end
        pend_valid = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        check_out(tag);
        repeat (gap) @(negedge clk);
        check_out("R2");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        strobe = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        check_out("R1");
        rst_n = 1'b1;
    endtask

    function automatic logic [21:0] pick();
        int r;
        r = $urandom % 8;
        case (r)
            0: return 22'h1FFFFF;
            1: return 22'h200000;
            2: return 22'h3FFFFF;
            3: return 22'($urandom % 300);
            default: return 22'($urandom);
        endcase
    endfunction

    initial begin
        #(10 * 200000);
        checks++;
        failures++;
        $display("FAIL R9 watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        do_reset();

        // R2: first strobe after reset leaves zeros.
        frame({22'h000040, 22'h200000, 22'h1FFFFF, 22'h3FFFFF}, 3, "R2");
        // R3 R4 R5: per-channel error evolution: -1 carries, max saturates, min clamps.
        frame({22'h000040, 22'h200000, 22'h1FFFFF, 22'h3FFFFF}, 3, "R3 R4 R5 R6 R7");
        frame({22'h000040, 22'h200000, 22'h1FFFFF, 22'h3FFFFF}, 3, "R4 R5");
        frame({22'h000040, 22'h200000, 22'h1FFFFF, 22'h3FFFFF}, 3, "R3 R5");
        frame({22'h000000, 22'h000000, 22'h000000, 22'h000000}, 5, "R3 R6");
        frame({22'h0001FF, 22'h03FE00, 22'h3C0000, 22'h000200}, 3, "R7 R9");
        frame({22'h000000, 22'h000000, 22'h000000, 22'h000000}, 4, "R7");

        for (int n = 0; n < 300; n++) begin
            frame({pick(), pick(), pick(), pick()}, 3 + ($urandom % 6), "R3 R4 R5 R6 R7");
        end

        // R1: reset mid-run clears outputs and error state.
        do_reset();
        frame({22'h3FFFFF, 22'h000070, 22'h1FFFFF, 22'h000001}, 3, "R1 R2");
        frame({22'h3FFFFF, 22'h000070, 22'h1FFFFF, 22'h000001}, 3, "R1 R3");
        frame({22'h3FFFFF, 22'h000070, 22'h1FFFFF, 22'h000001}, 3, "R1 R4");
        frame('0, 3, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule